// File: doc/BRIEF.md
# Presettable Down Counter with Terminal Zero Flag

This block is a binary down counter whose width is a parameter (eight bits by default). Every control input is active low: a clear that forces the count to all ones, a preset that forces an external load value into the count without waiting for the clock, a clocked load, and a count enable. A single active-low output, `zero_n`, flags that the count has reached zero while counting is enabled.

In normal use the count drops by one on every rising clock edge. From zero it wraps to all ones, so a free-running stage repeats every 2^WIDTH clocks. Stages chain into a wider counter by feeding `zero_n` of a lower stage into `cen_n` of the stage above, so the upper stage only steps while every lower stage sits at zero. A divider by N+1 results from tying `zero_n` back to `sload_n` with N on `load_val_i`.

Top module: `preset_downcounter`

## Requirements
- R1: While `clr_n` is low, `count_o` is all ones (255 at the default width) at once, with no clock edge needed, whatever the other inputs are.
- R2: With `clr_n`, `aload_n` and `sload_n` high and `cen_n` low, each rising clock edge lowers `count_o` by one.
- R3: With `clr_n`, `aload_n` and `sload_n` high and `cen_n` high, `count_o` does not change across clock edges.
- R4: With `clr_n` and `aload_n` high and `sload_n` low, the next rising edge copies `load_val_i` into `count_o` whether `cen_n` is high or low; `load_val_i` is one unsigned word with bit WIDTH-1 most significant and bit 0 least significant.
- R5: While `aload_n` is low (and `clr_n` high), `count_o` equals `load_val_i` with no clock edge needed; clock edges, `sload_n` and `cen_n` have no effect until `aload_n` returns high, after which clocked operation resumes from that value.
- R6: `clr_n` takes priority over `aload_n`: with both low the count is all ones; releasing only `clr_n` shows `load_val_i`.
- R7: When the count is zero and only `cen_n` is low, the next edge yields all ones, so a free run spans 2^WIDTH clocks.
- R8: `zero_n` is low exactly when `count_o` is zero and `cen_n` is low; raising `cen_n` at zero returns `zero_n` high without a clock edge.
- R9: During a free run, `zero_n` is low for exactly one clock period out of every 2^WIDTH.
- R10: With `zero_n` wired to `sload_n` and value N on `load_val_i`, `zero_n` falls once every N+1 clocks.
- R11: With a lower stage's `zero_n` driving an upper stage's `cen_n`, the upper stage holds while the lower count is non-zero and steps down by one on the edge where the lower stage wraps from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear to all ones, active low, highest priority |
| aload_n | input | 1 | Asynchronous forced load of `load_val_i`, active low |
| sload_n | input | 1 | Clocked load of `load_val_i`, active low |
| cen_n | input | 1 | Count enable, active low; also gates `zero_n` |
| load_val_i | input | WIDTH | Value used by both loads, MSB first |
| count_o | output | WIDTH | Present count |
| zero_n | output | 1 | Terminal flag, low when count is zero and `cen_n` is low |

## Verification
The properties watch the clocked behaviour on every edge outside the two forced states: a decrement under enable, no change with the enable off, the clocked load, the wrap from zero to all ones, and the terminal flag never staying low for two edges in a row while no load is pending. Everything that happens between edges (the clear and forced load taking effect at once, the priority of clear over forced load, the flag reacting to the enable at level) is only shown by the bench's directed scenarios. The full 256-clock period, the N+1 divider loop and the two-stage chain are likewise whole-run behaviours that the bench measures rather than single-edge properties.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;
   // Action chosen for the coming edge, in descending priority.
   typedef enum logic [2:0] {
      ACT_CLEAR = 3'd0,
      ACT_FORCE = 3'd1,
      ACT_LOAD  = 3'd2,
      ACT_HOLD  = 3'd3,
      ACT_DEC   = 3'd4
   } pdc_act_e;
endpackage

// File: rtl/pdc_decode.sv
`timescale 1ns/1ps
module pdc_decode (
   input  logic              clr_n,
   input  logic              aload_n,
   input  logic              sload_n,
   input  logic              cen_n,
   output pdc_pkg::pdc_act_e act_o
);
   import pdc_pkg::*;

   // Strict priority: clear, forced load, clocked load, enable.
   always_comb begin
      if (!clr_n)        act_o = ACT_CLEAR;
      else if (!aload_n) act_o = ACT_FORCE;
      else if (!sload_n) act_o = ACT_LOAD;
      else if (cen_n)    act_o = ACT_HOLD;
      else               act_o = ACT_DEC;
   end
endmodule

// File: rtl/pdc_nextval.sv
`timescale 1ns/1ps
module pdc_nextval #(
   parameter int WIDTH        = 8,
   parameter bit BORROW_CHAIN = 1'b0
) (
   input  pdc_pkg::pdc_act_e act_i,
   input  logic [WIDTH-1:0]  cur_i,
   input  logic [WIDTH-1:0]  load_val_i,
   output logic [WIDTH-1:0]  nxt_o
);
   import pdc_pkg::*;

   localparam logic [WIDTH-1:0] ALL_ONES = '1;
   localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

   if (WIDTH < 2) begin : g_bad_width
      $error("pdc_nextval: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] dec_v;

   // Two decrement variants: explicit borrow ripple or plain subtraction.
   if (BORROW_CHAIN) begin : g_chain
      always_comb begin
         logic brw;
         brw = 1'b1;
         for (int b = 0; b < WIDTH; b++) begin
            dec_v[b] = cur_i[b] ^ brw;
            brw      = brw & ~cur_i[b];
         end
      end
   end else begin : g_arith
      assign dec_v = cur_i - ONE;
   end

   always_comb begin
      case (act_i)
         ACT_CLEAR: nxt_o = ALL_ONES;
         ACT_FORCE: nxt_o = load_val_i;
         ACT_LOAD:  nxt_o = load_val_i;
         ACT_HOLD:  nxt_o = cur_i;
         ACT_DEC:   nxt_o = dec_v;
         default:   nxt_o = cur_i;
      endcase
   end
endmodule

// File: rtl/pdc_state.sv
`timescale 1ns/1ps
module pdc_state #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             aload_n,
   input  logic [WIDTH-1:0] load_val_i,
   input  logic [WIDTH-1:0] nxt_i,
   output logic [WIDTH-1:0] count_o
);
   localparam logic [WIDTH-1:0] ALL_ONES = '1;

   if (WIDTH < 2) begin : g_bad_width
      $error("pdc_state: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk or negedge clr_n or negedge aload_n) begin
      if (!clr_n)        cnt_q <= ALL_ONES;
      else if (!aload_n) cnt_q <= load_val_i;
      else               cnt_q <= nxt_i;
   end

   // Level overrides so the forced values are visible at once and
   // track the load value while the forced load is held.
   assign count_o = !clr_n   ? ALL_ONES   :
                    !aload_n ? load_val_i : cnt_q;
endmodule

// File: rtl/pdc_term.sv
`timescale 1ns/1ps
module pdc_term #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] cnt_i,
   input  logic             cen_n,
   output logic             zero_n
);
   if (WIDTH < 2) begin : g_bad_width
      $error("pdc_term: WIDTH must be at least 2");
   end

   logic at_zero;
   assign at_zero = ~|cnt_i;
   assign zero_n  = ~(at_zero & ~cen_n);
endmodule

// File: rtl/preset_downcounter.sv
`timescale 1ns/1ps
module preset_downcounter #(
   parameter int WIDTH        = 8,
   parameter bit BORROW_CHAIN = 1'b0
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             aload_n,
   input  logic             sload_n,
   input  logic             cen_n,
   input  logic [WIDTH-1:0] load_val_i,
   output logic [WIDTH-1:0] count_o,
   output logic             zero_n
);
   import pdc_pkg::*;

   localparam logic [WIDTH-1:0] ALL_ONES = '1;
   localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};
   localparam logic [WIDTH-1:0] ZERO     = '0;

   if (WIDTH < 2) begin : g_bad_width
      $error("preset_downcounter: WIDTH must be at least 2");
   end

   pdc_act_e         act;
   logic [WIDTH-1:0] nxt;

   pdc_decode u_decode (
      .clr_n   (clr_n),
      .aload_n (aload_n),
      .sload_n (sload_n),
      .cen_n   (cen_n),
      .act_o   (act)
   );

   pdc_nextval #(.WIDTH(WIDTH), .BORROW_CHAIN(BORROW_CHAIN)) u_next (
      .act_i      (act),
      .cur_i      (count_o),
      .load_val_i (load_val_i),
      .nxt_o      (nxt)
   );

   pdc_state #(.WIDTH(WIDTH)) u_state (
      .clk        (clk),
      .clr_n      (clr_n),
      .aload_n    (aload_n),
      .load_val_i (load_val_i),
      .nxt_i      (nxt),
      .count_o    (count_o)
   );

   pdc_term #(.WIDTH(WIDTH)) u_term (
      .cnt_i  (count_o),
      .cen_n  (cen_n),
      .zero_n (zero_n)
   );

   // R2: enabled count steps down by one
   p_dec_step_r2: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
      (sload_n && !cen_n) |=> (count_o == $past(count_o) - ONE))
      else $error("p_dec_step_r2 violated");

   // R3: disabled count keeps its value
   p_hold_r3: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
      (sload_n && cen_n) |=> $stable(count_o))
      else $error("p_hold_r3 violated");

   // R4: clocked load takes the load value regardless of enable
   p_sync_load_r4: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
      (!sload_n) |=> (count_o == $past(load_val_i)))
      else $error("p_sync_load_r4 violated");

   // R7: zero wraps to all ones
   p_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
      (sload_n && !cen_n && count_o == ZERO) |=> (count_o == ALL_ONES))
      else $error("p_wrap_r7 violated");

   // R9: flag never low on two successive edges without a load
   p_flag_single_r9: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
      (!zero_n && sload_n) |=> zero_n)
      else $error("p_flag_single_r9 violated");
endmodule

// File: tb/test_preset_downcounter.sv
`timescale 1ns/1ps
module test_preset_downcounter;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         clr_r = 1'b0, aload_r = 1'b1, sload_r = 1'b1, cen_r = 1'b1;
   logic [W-1:0] val_r = '0;
   logic         fb_mode = 1'b0;
   logic         sload_drv;
   logic [W-1:0] count;
   logic         zero_n;

   logic         hi_clr_r = 1'b0, hi_aload_r = 1'b1;
   logic [W-1:0] hi_val_r = '0;
   logic [W-1:0] hi_count;
   logic         hi_zero_n;

   int total = 0;
   int bad   = 0;
   int flag_lows = 0;
   bit done = 1'b0;

   logic [W:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   assign sload_drv = fb_mode ? zero_n : sload_r;

   preset_downcounter #(.WIDTH(W)) i_preset_downcounter (
      .clk(clk), .clr_n(clr_r), .aload_n(aload_r), .sload_n(sload_drv),
      .cen_n(cen_r), .load_val_i(val_r), .count_o(count), .zero_n(zero_n)
   );

   // Upper stage of a two-stage chain: enable from the lower flag (R11)
   preset_downcounter #(.WIDTH(W)) i_preset_downcounter_hi (
      .clk(clk), .clr_n(hi_clr_r), .aload_n(hi_aload_r), .sload_n(1'b1),
      .cen_n(zero_n), .load_val_i(hi_val_r), .count_o(hi_count), .zero_n(hi_zero_n)
   );

   task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual flag/count=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: called at negedge+1; drives, queues the expectation, waits past one edge.
   task automatic step(input logic c, input logic a, input logic s, input logic e,
                       input logic [W-1:0] v, input logic [W-1:0] exp_cnt,
                       input logic exp_flag, input string req);
      clr_r = c; aload_r = a; sload_r = s; cen_r = e; val_r = v;
      exp_q.push_back({exp_flag, exp_cnt});
      tag_q.push_back(req);
      @(negedge clk);
      #1;
   endtask

   // Monitor: compares one queued expectation per falling edge.
   always @(negedge clk) begin
      if (!zero_n) flag_lows++;
      if (exp_q.size() > 0) begin
         logic [W:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, {zero_n, count}, e);
      end
   end

   initial begin
      logic [W-1:0] m;
      int lows[$];
      #1;
      check("R1 clear at start", {zero_n, count}, {1'b1, 8'hFF});
      @(negedge clk); #1;

      step(1, 1, 1, 1, 8'h00, 8'hFF, 1, "R3 hold after clear");
      step(1, 1, 1, 0, 8'h00, 8'hFE, 1, "R2 first decrement");
      step(1, 1, 1, 0, 8'h00, 8'hFD, 1, "R2 second decrement");
      step(1, 1, 0, 1, 8'h80, 8'h80, 1, "R4 load with enable off");
      step(1, 1, 1, 0, 8'h80, 8'h7F, 1, "R4 MSB order after load");
      step(1, 1, 0, 0, 8'h21, 8'h21, 1, "R4 load with enable on");

      // R5: forced load visible before any edge, then edges ignored
      aload_r = 0; sload_r = 0; cen_r = 0; val_r = 8'h5A;
      #0.5;
      check("R5 forced load without edge", {zero_n, count}, {1'b1, 8'h5A});
      step(1, 0, 0, 0, 8'h5A, 8'h5A, 1, "R5 edge ignored while forced");
      step(1, 1, 1, 0, 8'h5A, 8'h59, 1, "R5 resume after release");

      // R6 / R1: clear beats forced load, both at level
      clr_r = 0; aload_r = 0; val_r = 8'h3C;
      #0.5;
      check("R6 clear over forced load", {zero_n, count}, {1'b1, 8'hFF});
      step(0, 0, 1, 1, 8'h3C, 8'hFF, 1, "R1 clear holds over edge");
      clr_r = 1;
      #0.5;
      check("R6 forced load after clear release", {zero_n, count}, {1'b1, 8'h3C});
      step(1, 0, 1, 1, 8'h3C, 8'h3C, 1, "R5 forced value kept");
      step(1, 1, 1, 1, 8'h3C, 8'h3C, 1, "R3 hold after release");

      // R8: flag at zero, gated by enable
      step(1, 1, 0, 1, 8'h01, 8'h01, 1, "R4 load one");
      step(1, 1, 1, 0, 8'h01, 8'h00, 0, "R8 flag low at zero");
      cen_r = 1;
      #0.5;
      check("R8 enable off lifts flag", {zero_n, count}, {1'b1, 8'h00});
      step(1, 1, 1, 0, 8'h00, 8'hFF, 1, "R7 wrap to all ones");

      // R7 / R9: full free-running period
      m = 8'hFF;
      flag_lows = 0;
      for (int i = 0; i < 256; i++) begin
         m = m - 8'd1;
         step(1, 1, 1, 0, 8'h00, m, (m == 8'h00) ? 1'b0 : 1'b1, "R7 free run");
      end
      check("R7 back to start after 256", {1'b0, count}, {1'b0, 8'hFF});
      check("R9 one low flag per period", {1'b0, 8'(flag_lows)}, {1'b0, 8'd1});

      // R10: divider with feedback, N = 5
      step(1, 1, 0, 1, 8'd5, 8'd5, 1, "R10 preload N");
      fb_mode = 1; cen_r = 0;
      for (int i = 1; i <= 24; i++) begin
         @(negedge clk);
         if (!zero_n) lows.push_back(i);
      end
      #1;
      fb_mode = 0; sload_r = 1; cen_r = 1;
      check("R10 number of flag pulses", {1'b0, 8'(lows.size())}, {1'b0, 8'd4});
      if (lows.size() > 0)
         check("R10 first pulse after N edges", {1'b0, 8'(lows[0])}, {1'b0, 8'd5});
      for (int k = 1; k < lows.size(); k++)
         check("R10 pulse spacing N+1", {1'b0, 8'(lows[k] - lows[k-1])}, {1'b0, 8'd6});

      // R11: two-stage chain
      hi_clr_r = 1; hi_aload_r = 0; hi_val_r = 8'd3;
      step(1, 0, 1, 0, 8'd2, 8'd2, 1, "R11 preset lower");
      check("R11 upper preset", {1'b0, hi_count}, {1'b0, 8'd3});
      hi_aload_r = 1;
      step(1, 1, 1, 0, 8'd2, 8'd1, 1, "R11 lower steps");
      check("R11 upper holds at lower 1", {1'b0, hi_count}, {1'b0, 8'd3});
      step(1, 1, 1, 0, 8'd2, 8'd0, 0, "R11 lower at zero");
      check("R11 upper holds at lower 0", {1'b0, hi_count}, {1'b0, 8'd3});
      step(1, 1, 1, 0, 8'd2, 8'hFF, 1, "R11 lower wraps");
      check("R11 upper steps on wrap", {1'b0, hi_count}, {1'b0, 8'd2});
      step(1, 1, 1, 0, 8'd2, 8'hFE, 1, "R11 lower continues");
      check("R11 upper holds again", {1'b0, hi_count}, {1'b0, 8'd2});

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
         $finish;
      end
   end
endmodule